// File: doc/BRIEF.md
# Per-Core Interrupt Router

This block collects interrupt lines that are local to a cluster of cores and delivers them to each core as an IRQ level and an FIQ level. Each core has four timer lines and four mailbox lines. All cores share one GPU interrupt with its IRQ and FIQ lines, and each core has its own PMU line. Software configures the routing through a small register bus, using byte addresses and 32-bit words. Writes take effect at the clock edge. Reads are combinational from the address.

Each timer line is masked by a per-core control word that holds an IRQ enable and an FIQ enable for each timer. When a timer's FIQ enable is set, that timer goes to FIQ only. The GPU IRQ and the GPU FIQ are each steered to one core by a routing word. The per-core PMU enables are changed only through a write-1-to-set address and a write-1-to-clear address. Each core's IRQ and FIQ pending words show the masked source levels and follow them without a clock. A core's output is high while any bit of the matching pending word is set.

Top module: `core_irq_router`

## Requirements
- R1: After reset, every timer control word reads 0, the routing word reads 0 and the PMU enable mask reads 0. All outputs are low while no source is active.
- R2: Bit t (0..3) of a core's IRQ pending word is set when timer line t of that core is high, its IRQ enable (control bit t) is set and its FIQ enable (control bit t+4) is clear.
- R3: Bit t of a core's FIQ pending word is set when timer line t is high and control bit t+4 is set. That timer's IRQ pending bit then stays clear, whatever control bit t holds.
- R4: Mailbox line m (0..3) of a core shows unmasked in bit 4+m of that core's IRQ pending word. FIQ pending bits 7:4 always read 0.
- R5: The GPU IRQ line appears in IRQ pending bit 8 only on the core named by routing bits 1:0. The GPU FIQ line appears in FIQ pending bit 8 only on the core named by routing bits 3:2. Bits 3:0 of the routing word read back as written.
- R6: Writing 1 to bit n at 0x010 sets the PMU enable of core n. Writing 1 to bit n at 0x014 clears it. Zero bits leave the enables unchanged. Reads of either address return the mask in bits 3:0.
- R7: IRQ pending bit 9 of core n is set when the PMU line of core n is high and its enable is set. FIQ pending bit 9 reads 0.
- R8: Pending words are read-only. Writes to their addresses change no register state and no output.
- R9: core_irq[n] is high exactly when core n's IRQ pending word is nonzero, and core_fiq[n] exactly when its FIQ pending word is nonzero. Both follow a configuration write in the cycle after that write's clock edge.
- R10: Address map: the routing word is at 0x00C, the timer control of core n at 0x040+4n, the IRQ pending of core n at 0x060+4n and the FIQ pending of core n at 0x070+4n. Timer control bits 31:8 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tmr_lines | input | NCORES*4 | Timer lines, 4 per core, core n at [4n+3:4n] |
| mbox_lines | input | NCORES*4 | Mailbox pending lines, 4 per core |
| gpu_irq | input | 1 | Shared GPU interrupt, IRQ flavour |
| gpu_fiq | input | 1 | Shared GPU interrupt, FIQ flavour |
| pmu_lines | input | NCORES | PMU interrupt line of each core |
| core_irq | output | NCORES | IRQ level to each core |
| core_fiq | output | NCORES | FIQ level to each core |

## Verification
Two functions can act in the same cycle: a configuration write and a source that is already active on that core. The hardest case is a write that sets the FIQ enable of a timer whose line is high and whose IRQ enable is already set. The bench provokes this on core 0. It then checks, in the cycle after the write edge, that core_irq has dropped and core_fiq has risen together, with no cycle where both or neither are high. The GPU routing is judged the same way: both GPU lines stay high while the routing word is rewritten, and every core's pending word is read back afterwards.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int TMR_N   = 4;
  localparam int MBOX_N  = 4;
  localparam int CTRL_W  = 2 * TMR_N;
  localparam int BIT_MBX = TMR_N;
  localparam int BIT_GPU = BIT_MBX + MBOX_N;
  localparam int BIT_PMU = BIT_GPU + 1;
  localparam int PEND_W  = BIT_PMU + 1;

  localparam logic [7:0] A_GPU_ROUTE = 8'h0C;
  localparam logic [7:0] A_PMU_SET   = 8'h10;
  localparam logic [7:0] A_PMU_CLR   = 8'h14;
  localparam logic [7:0] A_TMR_CTRL  = 8'h40;
  localparam logic [7:0] A_IRQ_PEND  = 8'h60;
  localparam logic [7:0] A_FIQ_PEND  = 8'h70;

  // timer lines that land on IRQ: enabled for IRQ and not claimed by FIQ
  function automatic logic [TMR_N-1:0] tmr_to_irq(logic [CTRL_W-1:0] ctrl,
                                                  logic [TMR_N-1:0] lines);
    return lines & ctrl[TMR_N-1:0] & ~ctrl[CTRL_W-1:TMR_N];
  endfunction

  function automatic logic [TMR_N-1:0] tmr_to_fiq(logic [CTRL_W-1:0] ctrl,
                                                  logic [TMR_N-1:0] lines);
    return lines & ctrl[CTRL_W-1:TMR_N];
  endfunction

  function automatic logic [31:0] set_clr(logic [31:0] cur, logic do_set,
                                          logic do_clr, logic [31:0] bits);
    logic [31:0] nxt;
    nxt = cur;
    if (do_set) nxt = nxt | bits;
    if (do_clr) nxt = nxt & ~bits;
    return nxt;
  endfunction

  function automatic logic [7:0] slot(logic [7:0] base, int idx);
    return base + 8'(4 * idx);
  endfunction
endpackage

// File: rtl/cir_regs.sv
module cir_regs
  import cir_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [NCORES*CTRL_W-1:0] tmr_ctrl,
  output logic [2*$clog2(NCORES)-1:0] gpu_route,
  output logic [NCORES-1:0]        pmu_en,
  output logic                     pmu_set_hit,
  output logic                     pmu_clr_hit
);
  localparam int SELW = $clog2(NCORES);

  logic route_hit;
  logic unused_wdata_hi;

  assign pmu_set_hit     = bus_wr && (bus_addr == A_PMU_SET);
  assign pmu_clr_hit     = bus_wr && (bus_addr == A_PMU_CLR);
  assign route_hit       = bus_wr && (bus_addr == A_GPU_ROUTE);
  assign unused_wdata_hi = ^bus_wdata[31:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpu_route <= '0;
      pmu_en    <= '0;
    end else begin
      if (route_hit) gpu_route <= bus_wdata[2*SELW-1:0];
      pmu_en <= NCORES'(set_clr(32'(pmu_en), pmu_set_hit, pmu_clr_hit, bus_wdata));
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_ctrl
    logic hit;
    assign hit = bus_wr && (bus_addr == slot(A_TMR_CTRL, c));
    always_ff @(posedge clk) begin
      if (!rst_n)   tmr_ctrl[c*CTRL_W +: CTRL_W] <= '0;
      else if (hit) tmr_ctrl[c*CTRL_W +: CTRL_W] <= bus_wdata[CTRL_W-1:0];
    end
  end
endmodule

// File: rtl/cir_core_pend.sv
module cir_core_pend
  import cir_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [TMR_N-1:0]  tmr_lines,
  input  logic [MBOX_N-1:0] mbox_lines,
  input  logic              gpu_irq_here,
  input  logic              gpu_fiq_here,
  input  logic              pmu_here,
  output logic [PEND_W-1:0] irq_pend,
  output logic [PEND_W-1:0] fiq_pend,
  output logic              irq_o,
  output logic              fiq_o
);
  always_comb begin
    irq_pend = '0;
    fiq_pend = '0;
    irq_pend[TMR_N-1:0]             = tmr_to_irq(ctrl, tmr_lines);
    fiq_pend[TMR_N-1:0]             = tmr_to_fiq(ctrl, tmr_lines);
    irq_pend[BIT_MBX +: MBOX_N]     = mbox_lines;
    irq_pend[BIT_GPU]               = gpu_irq_here;
    fiq_pend[BIT_GPU]               = gpu_fiq_here;
    irq_pend[BIT_PMU]               = pmu_here;
  end

  assign irq_o = |irq_pend;
  assign fiq_o = |fiq_pend;
endmodule

// File: rtl/cir_rdmux.sv
module cir_rdmux
  import cir_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic [7:0]                  bus_addr,
  input  logic [NCORES*CTRL_W-1:0]    tmr_ctrl,
  input  logic [2*$clog2(NCORES)-1:0] gpu_route,
  input  logic [NCORES-1:0]           pmu_en,
  input  logic [NCORES*PEND_W-1:0]    irq_pend_all,
  input  logic [NCORES*PEND_W-1:0]    fiq_pend_all,
  output logic [31:0]                 bus_rdata
);
  localparam int SELW = $clog2(NCORES);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_GPU_ROUTE) bus_rdata[2*SELW-1:0] = gpu_route;
    if (bus_addr == A_PMU_SET || bus_addr == A_PMU_CLR) bus_rdata[NCORES-1:0] = pmu_en;
    for (int c = 0; c < NCORES; c++) begin
      if (bus_addr == slot(A_TMR_CTRL, c)) bus_rdata[CTRL_W-1:0] = tmr_ctrl[c*CTRL_W +: CTRL_W];
      if (bus_addr == slot(A_IRQ_PEND, c)) bus_rdata[PEND_W-1:0] = irq_pend_all[c*PEND_W +: PEND_W];
      if (bus_addr == slot(A_FIQ_PEND, c)) bus_rdata[PEND_W-1:0] = fiq_pend_all[c*PEND_W +: PEND_W];
    end
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import cir_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NCORES*TMR_N-1:0] tmr_lines,
  input  logic [NCORES*MBOX_N-1:0] mbox_lines,
  input  logic                    gpu_irq,
  input  logic                    gpu_fiq,
  input  logic [NCORES-1:0]       pmu_lines,
  output logic [NCORES-1:0]       core_irq,
  output logic [NCORES-1:0]       core_fiq
);
  localparam int SELW = $clog2(NCORES);

  logic [NCORES*CTRL_W-1:0] tmr_ctrl;
  logic [2*SELW-1:0]        gpu_route;
  logic [NCORES-1:0]        pmu_en;
  logic                     pmu_set_hit;
  logic                     pmu_clr_hit;
  logic [NCORES*PEND_W-1:0] irq_pend_all;
  logic [NCORES*PEND_W-1:0] fiq_pend_all;
  logic [SELW-1:0]          gpu_irq_core;
  logic [SELW-1:0]          gpu_fiq_core;

  assign gpu_irq_core = gpu_route[SELW-1:0];
  assign gpu_fiq_core = gpu_route[2*SELW-1:SELW];

  cir_regs #(.NCORES(NCORES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tmr_ctrl(tmr_ctrl), .gpu_route(gpu_route),
    .pmu_en(pmu_en), .pmu_set_hit(pmu_set_hit), .pmu_clr_hit(pmu_clr_hit)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    cir_core_pend u_pend (
      .ctrl         (tmr_ctrl[c*CTRL_W +: CTRL_W]),
      .tmr_lines    (tmr_lines[c*TMR_N +: TMR_N]),
      .mbox_lines   (mbox_lines[c*MBOX_N +: MBOX_N]),
      .gpu_irq_here (gpu_irq && (gpu_irq_core == SELW'(c))),
      .gpu_fiq_here (gpu_fiq && (gpu_fiq_core == SELW'(c))),
      .pmu_here     (pmu_lines[c] && pmu_en[c]),
      .irq_pend     (irq_pend_all[c*PEND_W +: PEND_W]),
      .fiq_pend     (fiq_pend_all[c*PEND_W +: PEND_W]),
      .irq_o        (core_irq[c]),
      .fiq_o        (core_fiq[c])
    );
  end

  cir_rdmux #(.NCORES(NCORES)) u_rdmux (
    .bus_addr(bus_addr), .tmr_ctrl(tmr_ctrl), .gpu_route(gpu_route),
    .pmu_en(pmu_en), .irq_pend_all(irq_pend_all), .fiq_pend_all(fiq_pend_all),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/cir_router_chk.sv
module cir_router_chk
  import cir_pkg::*;
#(
  parameter int NCORES = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [7:0]               bus_addr,
  input logic [31:0]              bus_wdata,
  input logic [NCORES*TMR_N-1:0]  tmr_lines,
  input logic [NCORES*MBOX_N-1:0] mbox_lines,
  input logic                     gpu_irq,
  input logic                     gpu_fiq,
  input logic [NCORES-1:0]        pmu_lines,
  input logic [NCORES-1:0]        pmu_en,
  input logic [NCORES*PEND_W-1:0] irq_pend_all,
  input logic [NCORES*PEND_W-1:0] fiq_pend_all,
  input logic [NCORES-1:0]        core_irq,
  input logic [NCORES-1:0]        core_fiq
);
  logic [NCORES-1:0] gpu_irq_seen;
  logic [NCORES-1:0] gpu_fiq_seen;
  logic              all_quiet;

  assign all_quiet = (tmr_lines == '0) && (mbox_lines == '0) && !gpu_irq &&
                     !gpu_fiq && (pmu_lines == '0);

  for (genvar c = 0; c < NCORES; c++) begin : g_chk
    assign gpu_irq_seen[c] = irq_pend_all[c*PEND_W + BIT_GPU];
    assign gpu_fiq_seen[c] = fiq_pend_all[c*PEND_W + BIT_GPU];

    AST_FIQ_EXCLUDES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_all[c*PEND_W +: TMR_N] & fiq_pend_all[c*PEND_W +: TMR_N]) == '0); // R3
    AST_MBOX_NOT_ON_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_pend_all[c*PEND_W + BIT_MBX +: MBOX_N] == '0); // R4
    AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      all_quiet |-> !core_irq[c] && !core_fiq[c]); // R9
    AST_PMU_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend_all[c*PEND_W + BIT_PMU] |-> pmu_lines[c] && pmu_en[c]); // R7
  end

  AST_GPU_IRQ_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_irq_seen) && (gpu_irq == (gpu_irq_seen != '0))); // R5
  AST_GPU_FIQ_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_fiq_seen) && (gpu_fiq == (gpu_fiq_seen != '0))); // R5
  AST_PMU_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PMU_SET) |=>
      (pmu_en & $past(bus_wdata[NCORES-1:0])) == $past(bus_wdata[NCORES-1:0])); // R6
  AST_PMU_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PMU_CLR) |=> (pmu_en & $past(bus_wdata[NCORES-1:0])) == '0); // R6
  AST_PMU_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_PMU_SET || bus_addr == A_PMU_CLR)) |=> $stable(pmu_en)); // R6
endmodule

bind core_irq_router cir_router_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tmr_lines(tmr_lines), .mbox_lines(mbox_lines),
  .gpu_irq(gpu_irq), .gpu_fiq(gpu_fiq), .pmu_lines(pmu_lines), .pmu_en(pmu_en),
  .irq_pend_all(irq_pend_all), .fiq_pend_all(fiq_pend_all),
  .core_irq(core_irq), .core_fiq(core_fiq)
);

// File: tb/core_irq_router_bench.sv
`timescale 1ns/1ps
module core_irq_router_bench;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC*4-1:0] tmr_lines = '0;
  logic [NC*4-1:0] mbox_lines = '0;
  logic          gpu_irq = 1'b0;
  logic          gpu_fiq = 1'b0;
  logic [NC-1:0] pmu_lines = '0;
  logic [NC-1:0] core_irq;
  logic [NC-1:0] core_fiq;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  core_irq_router #(.NCORES(NC)) u_core_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_lines(tmr_lines),
    .mbox_lines(mbox_lines), .gpu_irq(gpu_irq), .gpu_fiq(gpu_fiq),
    .pmu_lines(pmu_lines), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  // {core[1:0], ctrl[7:0], lines[3:0], exp_irq[3:0], exp_fiq[3:0]}
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 8'h0F, 4'hF, 4'hF, 4'h0},
    {2'd1, 8'hF0, 4'hF, 4'h0, 4'hF},
    {2'd2, 8'h3C, 4'hA, 4'h8, 4'h2},
    {2'd3, 8'hFF, 4'h5, 4'h0, 4'h5},
    {2'd0, 8'h05, 4'h3, 4'h1, 4'h0},
    {2'd1, 8'h00, 4'hF, 4'h0, 4'h0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      rd(8'h40 + 8'(4*c), v); check("R1 timer ctrl", v, 0);
    end
    rd(8'h0C, v); check("R1 routing", v, 0);
    rd(8'h10, v); check("R1 pmu mask", v, 0);
    check("R1 outputs", {core_irq, core_fiq}, 0);

    // R2 R3 R9 vector table
    foreach (VEC[i]) begin
      int c = int'(VEC[i][21:20]);
      wr(8'h40 + 8'(4*c), 32'(VEC[i][19:12]));
      @(negedge clk);
      tmr_lines = '0;
      tmr_lines[c*4 +: 4] = VEC[i][11:8];
      rd(8'h60 + 8'(4*c), v); check("R2 irq pending", v, 32'(VEC[i][7:4]));
      rd(8'h70 + 8'(4*c), v); check("R3 fiq pending", v, 32'(VEC[i][3:0]));
      check("R9 core_irq", 32'(core_irq[c]), 32'(|VEC[i][7:4]));
      check("R9 core_fiq", 32'(core_fiq[c]), 32'(|VEC[i][3:0]));
    end
    tmr_lines = '0;

    // R10 map edges
    rd(8'h04, v); check("R10 unmapped", v, 0);
    wr(8'h44, 32'hFFFF_FF5A);
    rd(8'h44, v); check("R10 ctrl upper bits", v, 32'h5A);

    // R4 mailbox pass-through
    @(negedge clk); mbox_lines[8 +: 4] = 4'h9;
    rd(8'h68, v); check("R4 mbox irq", v, 32'h90);
    rd(8'h78, v); check("R4 mbox fiq", v, 0);
    mbox_lines = '0;

    // R5 GPU routing
    @(negedge clk); gpu_irq = 1'b1; gpu_fiq = 1'b1;
    rd(8'h60, v); check("R5 gpu irq default core0", v, 32'h100);
    rd(8'h70, v); check("R5 gpu fiq default core0", v, 32'h100);
    wr(8'h0C, 32'hB);
    rd(8'h0C, v); check("R5 routing readback", v, 32'hB);
    for (int c = 0; c < NC; c++) begin
      rd(8'h60 + 8'(4*c), v); check("R5 gpu irq core", v, (c == 3) ? 32'h100 : 32'h0);
      rd(8'h70 + 8'(4*c), v); check("R5 gpu fiq core", v, (c == 2) ? 32'h100 : 32'h0);
    end
    @(negedge clk); gpu_irq = 1'b0; gpu_fiq = 1'b0;

    // R6 R7 PMU set/clear
    @(negedge clk); pmu_lines = 4'hF;
    rd(8'h60, v); check("R7 pmu disabled", v, 0);
    wr(8'h10, 32'h5);
    rd(8'h60, v); check("R7 pmu core0", v, 32'h200);
    rd(8'h68, v); check("R7 pmu core2", v, 32'h200);
    rd(8'h64, v); check("R7 pmu core1 off", v, 0);
    rd(8'h70, v); check("R7 pmu not fiq", v, 0);
    wr(8'h10, 32'h0);
    rd(8'h14, v); check("R6 zero set no change", v, 32'h5);
    wr(8'h14, 32'h1);
    rd(8'h10, v); check("R6 clear core0", v, 32'h4);
    rd(8'h60, v); check("R7 pmu core0 cleared", v, 0);
    wr(8'h14, 32'h0);
    rd(8'h10, v); check("R6 zero clear no change", v, 32'h4);
    wr(8'h14, 32'hF);
    @(negedge clk); pmu_lines = '0;

    // R8 pending read-only
    rd(8'h44, v);
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h74, 32'hFFFF_FFFF);
    rd(8'h64, v); check("R8 irq pend write ignored", v, 0);
    rd(8'h74, v); check("R8 fiq pend write ignored", v, 0);
    rd(8'h44, v); check("R8 ctrl untouched", v, 32'h5A);
    check("R8 outputs quiet", {core_irq, core_fiq}, 0);

    // R9 R3 enable write while source active
    wr(8'h40, 32'h01);
    @(negedge clk); tmr_lines[0] = 1'b1;
    #1 check("R9 irq before override", {30'b0, core_irq[0], core_fiq[0]}, 32'h2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h11;
    #1 check("R9 unchanged before edge", {30'b0, core_irq[0], core_fiq[0]}, 32'h2);
    @(negedge clk); bus_wr = 1'b0;
    #1 check("R3 fiq wins after edge", {30'b0, core_irq[0], core_fiq[0]}, 32'h1);
    tmr_lines = '0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule